// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the purely combinational execute stage of a 32-bit load/store processor core. In one pass it takes two register operands, a 16-bit instruction immediate, a 5-bit shift count and a 5-bit operation code. It returns a 32-bit result and a signed-overflow indication. Bitwise logic, shifts, wrapping and trapping addition and subtraction, signed and unsigned comparison, and upper-immediate construction all share one adder, one shifter and one logic slice.

Each operation applies its own rule for widening the immediate. Bitwise forms widen it with zeros. Arithmetic and comparison forms copy its sign bit. The upper-immediate form moves it into the top half of the word. Only the trapping add and subtract forms may raise the overflow flag. Decoding the instruction word, reading the register file, taking the trap and driving memory all happen outside this block. The outputs follow the inputs with no clock.

Top module: `alu_exec_unit`

## Requirements
- R1: With op_sel 0 (AND) or 1 (OR), result is the bitwise AND or OR of src_a and src_b, and ovf is 0.
- R2: With op_sel 2 (AND immediate) or 3 (OR immediate), the second operand is imm padded with 16 zero bits above it, so bits 31..16 of result are 0 for AND and equal to src_a for OR. ovf is 0.
- R3: With op_sel 4 (left shift) or 5 (logical right shift), result is src_a shifted by shamt (0 to 31) with zeros in the vacated positions. A count of 0 returns src_a unchanged.
- R4: With op_sel 6 (arithmetic right shift), result is src_a shifted right by shamt, with every vacated position holding src_a bit 31.
- R5: With op_sel 7 (signed add), 9 (signed subtract, src_a minus src_b) or 11 (signed add immediate, imm sign-extended), result is the 32-bit wrapped value. ovf is 1 exactly when the true signed result lies outside the range -2^31 to 2^31-1.
- R6: With op_sel 8 (add), 10 (subtract) or 12 (add immediate, imm sign-extended), result is the wrapped sum or difference, and ovf is always 0.
- R7: With op_sel 13 (set-less-than) or 16 (set-less-than immediate, imm sign-extended), result is 1 when src_a is less than the second operand as signed numbers and 0 otherwise. Bits 31..1 are 0 and ovf is 0.
- R8: With op_sel 14 (unsigned set-less-than) or 17 (unsigned set-less-than immediate, imm sign-extended then compared as unsigned), result is 1 or 0 by unsigned comparison, and ovf is 0.
- R9: With op_sel 15 (load upper immediate), result holds imm in bits 31..16 and zeros in bits 15..0, whatever src_a and src_b hold. ovf is 0.
- R10: With op_sel 18 to 31 (unassigned), result is 0 and ovf is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code, values as listed in the requirements |
| src_a | input | 32 | First register operand, and the value that is shifted |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Instruction immediate |
| shamt | input | 5 | Shift count |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of the trapping add and subtract forms |

## Verification
The hardest cases to reach are the overflow corners. They need operands whose true sum or difference lands just outside the signed range. They also need the near misses right beside them: subtracting the most negative value, adding values of opposite sign at the extremes, and the signed and unsigned comparisons disagreeing whenever one operand has bit 31 set. The stimulus drives these extremes directly. It also drives the same operand pairs through both the trapping and the wrapping forms and through both comparison forms. A pseudo-random sweep over every operation code, with operands biased toward the signed extremes, then covers the rest.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [4:0] {
      OP_AND   = 5'd0,
      OP_OR    = 5'd1,
      OP_ANDI  = 5'd2,
      OP_ORI   = 5'd3,
      OP_SLL   = 5'd4,
      OP_SRL   = 5'd5,
      OP_SRA   = 5'd6,
      OP_ADD   = 5'd7,
      OP_ADDU  = 5'd8,
      OP_SUB   = 5'd9,
      OP_SUBU  = 5'd10,
      OP_ADDI  = 5'd11,
      OP_ADDIU = 5'd12,
      OP_SLT   = 5'd13,
      OP_SLTU  = 5'd14,
      OP_LUI   = 5'd15,
      OP_SLTI  = 5'd16,
      OP_SLTIU = 5'd17
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RLOG  = 2'd1,
      SH_RARITH = 2'd2
   } shift_mode_e;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            use_or,
   output logic [XLEN-1:0] y
);
   initial begin
      assert (XLEN >= 2) else $error("alu_logic_unit: XLEN too small");
   end

   genvar i;
   generate
      for (i = 0; i < XLEN; i++) begin : g_bit
         assign y[i] = use_or ? (a[i] | b[i]) : (a[i] & b[i]);
      end
   endgenerate

   always_comb begin
      if (!use_or) begin
         AST_AND_SUBSET: assert ((y & ~a) == '0 && (y & ~b) == '0); // R1
      end else begin
         AST_OR_SUPERSET: assert ((y & a) == a && (y & b) == b); // R1
      end
   end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
   import alu_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter bit BARREL  = 1'b1,
   localparam int SHW    = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] a,
   input  logic [SHW-1:0]  amt,
   input  shift_mode_e     mode,
   output logic [XLEN-1:0] y
);
   initial begin
      assert ((1 << SHW) == XLEN) else $error("alu_shift_unit: XLEN must be a power of two");
   end

   logic fill;
   assign fill = (mode == SH_RARITH) & a[XLEN-1];

   generate
      if (BARREL) begin : g_barrel
         logic [XLEN-1:0] stage [0:SHW];
         assign stage[0] = a;
         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int D = 1 << s;
            logic [XLEN-1:0] moved;
            assign moved = (mode == SH_LEFT) ? {stage[s][XLEN-1-D:0], {D{1'b0}}}
                                             : {{D{fill}}, stage[s][XLEN-1:D]};
            assign stage[s+1] = amt[s] ? moved : stage[s];
         end
         assign y = stage[SHW];
      end else begin : g_plain
         always_comb begin
            unique case (mode)
               SH_LEFT:   y = a << amt;
               SH_RARITH: y = $unsigned($signed(a) >>> amt);
               default:   y = a >> amt;
            endcase
         end
      end
   endgenerate

   always_comb begin
      if (amt == '0) begin
         AST_ZERO_COUNT: assert (y == a); // R3
      end else if (mode == SH_LEFT) begin
         AST_LEFT_LSB: assert (y[0] == 1'b0); // R3
      end else if (mode == SH_RLOG) begin
         AST_RLOG_MSB: assert (y[XLEN-1] == 1'b0); // R3
      end else begin
         AST_RARITH_MSB: assert (y[XLEN-1] == a[XLEN-1]); // R4
      end
   end
endmodule

// File: rtl/alu_addsub_unit.sv
module alu_addsub_unit #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            sub,
   output logic [XLEN-1:0] sum,
   output logic            sovf,
   output logic            cout
);
   logic [XLEN-1:0] b_eff;
   logic [XLEN:0]   wide;

   always_comb begin
      b_eff = sub ? ~b : b;
      wide  = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub};
      sum   = wide[XLEN-1:0];
      cout  = wide[XLEN];
      sovf  = (a[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
   end

   logic [XLEN:0] sext_ref;
   always_comb begin
      sext_ref = sub ? ({a[XLEN-1], a} - {b[XLEN-1], b})
                     : ({a[XLEN-1], a} + {b[XLEN-1], b});
      AST_SIGNED_OVF: assert (sovf == (sext_ref[XLEN] != sext_ref[XLEN-1])); // R5
      AST_WRAP_SUM: assert (sum == sext_ref[XLEN-1:0]); // R6
   end
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
   import alu_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int IMMW   = 16,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(XLEN),
   localparam int OPW   = 5,
   localparam int PADW  = XLEN - IMMW
) (
   input  logic [OPW-1:0]  op_sel,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   input  logic [IMMW-1:0] imm,
   input  logic [SHW-1:0]  shamt,
   output logic [XLEN-1:0] result,
   output logic            ovf
);
   initial begin
      assert (IMMW < XLEN) else $error("alu_exec_unit: immediate wider than word");
      assert (XLEN >= 8) else $error("alu_exec_unit: XLEN too small");
   end

   logic [XLEN-1:0] imm_sx, imm_zx, imm_up;
   assign imm_sx = {{PADW{imm[IMMW-1]}}, imm};
   assign imm_zx = {{PADW{1'b0}}, imm};
   assign imm_up = {imm, {PADW{1'b0}}};

   logic [XLEN-1:0] log_b, add_b;
   logic            log_or, add_sub;
   shift_mode_e     sh_mode;

   always_comb begin
      log_b   = src_b;
      log_or  = 1'b0;
      add_b   = src_b;
      add_sub = 1'b0;
      sh_mode = SH_LEFT;
      case (op_sel)
         OP_OR:    log_or = 1'b1;
         OP_ANDI:  log_b = imm_zx;
         OP_ORI:   begin log_b = imm_zx; log_or = 1'b1; end
         OP_SRL:   sh_mode = SH_RLOG;
         OP_SRA:   sh_mode = SH_RARITH;
         OP_SUB, OP_SUBU, OP_SLT, OP_SLTU: add_sub = 1'b1;
         OP_ADDI, OP_ADDIU: add_b = imm_sx;
         OP_SLTI, OP_SLTIU: begin add_b = imm_sx; add_sub = 1'b1; end
         default: ;
      endcase
   end

   logic [XLEN-1:0] log_y, sh_y, sum;
   logic            sovf, cout;

   alu_logic_unit #(.XLEN(XLEN)) u_logic (
      .a(src_a), .b(log_b), .use_or(log_or), .y(log_y)
   );

   alu_shift_unit #(.XLEN(XLEN), .BARREL(BARREL)) u_shift (
      .a(src_a), .amt(shamt), .mode(sh_mode), .y(sh_y)
   );

   alu_addsub_unit #(.XLEN(XLEN)) u_addsub (
      .a(src_a), .b(add_b), .sub(add_sub), .sum(sum), .sovf(sovf), .cout(cout)
   );

   logic lt_signed, lt_unsigned;
   assign lt_signed   = sum[XLEN-1] ^ sovf;
   assign lt_unsigned = ~cout;

   always_comb begin
      result = '0;
      ovf    = 1'b0;
      case (op_sel)
         OP_AND, OP_OR, OP_ANDI, OP_ORI: result = log_y;
         OP_SLL, OP_SRL, OP_SRA:         result = sh_y;
         OP_ADD, OP_SUB, OP_ADDI:        begin result = sum; ovf = sovf; end
         OP_ADDU, OP_SUBU, OP_ADDIU:     result = sum;
         OP_SLT, OP_SLTI:                result = {{(XLEN-1){1'b0}}, lt_signed};
         OP_SLTU, OP_SLTIU:              result = {{(XLEN-1){1'b0}}, lt_unsigned};
         OP_LUI:                         result = imm_up;
         default: ;
      endcase
   end

   always_comb begin
      if (op_sel > OPW'(OP_SLTIU)) begin
         AST_UNDEF_ZERO: assert (result == '0 && !ovf); // R10
      end
      if (op_sel == OPW'(OP_ADDU) || op_sel == OPW'(OP_SUBU) || op_sel == OPW'(OP_ADDIU)) begin
         AST_NO_OVERFLOW: assert (!ovf); // R6
      end
      if (op_sel == OPW'(OP_SLT) || op_sel == OPW'(OP_SLTU) ||
          op_sel == OPW'(OP_SLTI) || op_sel == OPW'(OP_SLTIU)) begin
         AST_SLT_BOOL: assert (result[XLEN-1:1] == '0 && !ovf); // R7 R8
      end
      if (op_sel == OPW'(OP_LUI)) begin
         AST_LUI_LOW: assert (result[PADW-1:0] == '0 && result[XLEN-1:PADW] == imm); // R9
      end
      if (op_sel == OPW'(OP_ANDI)) begin
         AST_ANDI_UPPER: assert (result[XLEN-1:IMMW] == '0); // R2
      end
   end
endmodule

// File: tb/test_alu_exec_unit.sv
module test_alu_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op_sel = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [15:0] imm = '0;
   logic [4:0]  shamt = '0;
   logic [31:0] result;
   logic        ovf;

   always #4 clk = ~clk;

   alu_exec_unit i_alu_exec_unit (
      .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm(imm),
      .shamt(shamt), .result(result), .ovf(ovf)
   );

   int checks = 0, fails = 0;
   logic [31:0] q_res[$];
   logic        q_ovf[$];
   string       q_tag[$];

   function automatic string tag_of(input logic [4:0] op);
      case (op)
         5'd0, 5'd1:           return "R1";
         5'd2, 5'd3:           return "R2";
         5'd4, 5'd5:           return "R3";
         5'd6:                 return "R4";
         5'd7, 5'd9, 5'd11:    return "R5";
         5'd8, 5'd10, 5'd12:   return "R6";
         5'd13, 5'd16:         return "R7";
         5'd14, 5'd17:         return "R8";
         5'd15:                return "R9";
         default:              return "R10";
      endcase
   endfunction

   // Independent reference computed from the requirement text.
   task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [4:0] sh,
                        output logic [31:0] r, output logic o);
      longint sa, sb, si, t;
      logic [31:0] isx;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      si = longint'($signed(im));
      isx = 32'(si);
      r = '0; o = 1'b0;
      case (op)
         5'd0: r = a & b;
         5'd1: r = a | b;
         5'd2: r = a & {16'h0, im};
         5'd3: r = a | {16'h0, im};
         5'd4: r = a << sh;
         5'd5: r = a >> sh;
         5'd6: begin
            r = a;
            for (int k = 0; k < int'(sh); k++) r = {a[31], r[31:1]};
         end
         5'd7, 5'd9, 5'd11: begin
            t = (op == 5'd7) ? sa + sb : (op == 5'd9) ? sa - sb : sa + si;
            r = 32'(t);
            o = (t > 64'sd2147483647) || (t < -64'sd2147483648);
         end
         5'd8:  r = a + b;
         5'd10: r = a - b;
         5'd12: r = a + isx;
         5'd13: r = {31'h0, sa < sb};
         5'd16: r = {31'h0, sa < si};
         5'd14: r = {31'h0, a < b};
         5'd17: r = {31'h0, a < isx};
         5'd15: r = {im, 16'h0};
         default: ;
      endcase
   endtask

   task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [4:0] sh,
                        input logic [31:0] er, input logic eo, input string tag);
      @(posedge clk);
      #1;
      op_sel = op; src_a = a; src_b = b; imm = im; shamt = sh;
      q_res.push_back(er); q_ovf.push_back(eo); q_tag.push_back(tag);
   endtask

   task automatic drive_m(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic [4:0] sh);
      logic [31:0] er;
      logic eo;
      model(op, a, b, im, sh, er, eo);
      drive(op, a, b, im, sh, er, eo, tag_of(op));
   endtask

   always @(negedge clk) begin
      if (q_res.size() > 0) begin
         logic [31:0] er;
         logic eo;
         string tg;
         er = q_res.pop_front(); eo = q_ovf.pop_front(); tg = q_tag.pop_front();
         checks++;
         if (result !== er || ovf !== eo) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d: got result=%h ovf=%b, expected result=%h ovf=%b",
                     tg, op_sel, src_a, src_b, imm, shamt, result, ovf, er, eo);
         end
      end
   end

   bit done = 0;
   initial begin
      int cyc = 0;
      while (!done && cyc < 50000) begin @(posedge clk); cyc++; end
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Reset-state inputs: all zero, AND gives 0
      drive(5'd0, 32'h0, 32'h0, 16'h0, 5'd0, 32'h0, 1'b0, "R1");
      drive(5'd0, 32'hB6A43D9A, 32'h00000FFF, 16'h0, 5'd0, 32'h00000D9A, 1'b0, "R1");
      drive(5'd1, 32'hF0F00000, 32'h0000F0F0, 16'h0, 5'd0, 32'hF0F0F0F0, 1'b0, "R1");
      drive(5'd2, 32'hB6A43D9A, 32'hFFFFFFFF, 16'h0FFF, 5'd0, 32'h00000D9A, 1'b0, "R2");
      drive(5'd3, 32'h12345678, 32'h0, 16'hFFFF, 5'd0, 32'h1234FFFF, 1'b0, "R2");
      drive(5'd2, 32'hFFFFFFFF, 32'h0, 16'h8001, 5'd0, 32'h00008001, 1'b0, "R2");
      drive(5'd4, 32'h12345678, 32'h0, 16'h0, 5'd8, 32'h34567800, 1'b0, "R3");
      drive(5'd5, 32'h12345678, 32'h0, 16'h0, 5'd8, 32'h00123456, 1'b0, "R3");
      drive(5'd5, 32'h92345678, 32'h0, 16'h0, 5'd0, 32'h92345678, 1'b0, "R3");
      drive(5'd4, 32'h80000001, 32'h0, 16'h0, 5'd31, 32'h80000000, 1'b0, "R3");
      drive(5'd6, 32'h92345678, 32'h0, 16'h0, 5'd8, 32'hFF923456, 1'b0, "R4");
      drive(5'd6, 32'h12345678, 32'h0, 16'h0, 5'd8, 32'h00123456, 1'b0, "R4");
      drive(5'd6, 32'h80000000, 32'h0, 16'h0, 5'd31, 32'hFFFFFFFF, 1'b0, "R4");
      drive(5'd7, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 32'h80000000, 1'b1, "R5");
      drive(5'd7, 32'h80000000, 32'hFFFFFFFF, 16'h0, 5'd0, 32'h7FFFFFFF, 1'b1, "R5");
      drive(5'd7, 32'h7FFFFFFF, 32'h80000000, 16'h0, 5'd0, 32'hFFFFFFFF, 1'b0, "R5");
      drive(5'd9, 32'h80000000, 32'h1, 16'h0, 5'd0, 32'h7FFFFFFF, 1'b1, "R5");
      drive(5'd9, 32'h0, 32'h80000000, 16'h0, 5'd0, 32'h80000000, 1'b1, "R5");
      drive(5'd9, 32'hFFFFFFFF, 32'h80000000, 16'h0, 5'd0, 32'h7FFFFFFF, 1'b0, "R5");
      drive(5'd11, 32'd100, 32'h0, 16'hFFCE, 5'd0, 32'd50, 1'b0, "R5");
      drive(5'd11, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, 32'h80000000, 1'b1, "R5");
      drive(5'd8, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 32'h80000000, 1'b0, "R6");
      drive(5'd10, 32'h80000000, 32'h1, 16'h0, 5'd0, 32'h7FFFFFFF, 1'b0, "R6");
      drive(5'd12, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, 32'h80000000, 1'b0, "R6");
      drive(5'd13, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h1, 1'b0, "R7");
      drive(5'd13, 32'h7FFFFFFF, 32'h80000000, 16'h0, 5'd0, 32'h0, 1'b0, "R7");
      drive(5'd13, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0, 32'h1, 1'b0, "R7");
      drive(5'd16, 32'hFFFFFFF0, 32'h0, 16'hFFFF, 5'd0, 32'h1, 1'b0, "R7");
      drive(5'd14, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h0, 1'b0, "R8");
      drive(5'd14, 32'h1, 32'h80000000, 16'h0, 5'd0, 32'h1, 1'b0, "R8");
      drive(5'd17, 32'd5, 32'h0, 16'hFFFF, 5'd0, 32'h1, 1'b0, "R8");
      drive(5'd14, 32'h5, 32'h5, 16'h0, 5'd0, 32'h0, 1'b0, "R8");
      drive(5'd15, 32'hDEADBEEF, 32'hCAFEF00D, 16'hABAB, 5'd7, 32'hABAB0000, 1'b0, "R9");
      drive(5'd18, 32'h7FFFFFFF, 32'h1, 16'hFFFF, 5'd3, 32'h0, 1'b0, "R10");
      drive(5'd31, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd31, 32'h0, 1'b0, "R10");
      // Sweep across every code with operands biased toward the signed extremes.
      lf = 32'hACE1_2345;
      for (int n = 0; n < 1200; n++) begin
         logic [31:0] a, b;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         a = lf;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         b = lf;
         if (n % 4 == 1) a = {~a[31], {31{a[31]}}};
         if (n % 6 == 2) b = {b[0], {31{~b[0]}}};
         drive_m(5'(n % 32), a, b, lf[15:0], lf[20:16]);
      end
      repeat (4) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule